// File: doc/BRIEF.md
# Way Write Variation Threshold Checker

This block takes the per-way write counts of one group of cache sets and decides whether the spread of those counts is large. The measure is the coefficient of variation in percent: one hundred times the sample standard deviation, which uses the divisor A−1, divided by the mean. The block compares this measure against a programmable whole-percent threshold. A wear-leveling controller uses the single-bit answer to decide whether it should shift write pressure away from the hottest way in that group.

The evaluation uses no square root and no divider. Both sides of the comparison are squared and multiplied across, so only integer multiplies and one magnitude compare remain. Internal widths are derived from the parameters so that no intermediate product can overflow.

A one-cycle `start` in the idle state captures the count vector and the threshold. The counts are then summed and squared one way per clock. Three further register stages follow, and `done` pulses once with the result on `exceeds_o`. The block finishes in A+3 cycles, which is 35 cycles for A=32.

Top module: `cv_threshold_check`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `exceeds_o` are all 0.
- R2: `counts_i` and `lambda_i` are sampled only on the clock edge that accepts `start_i`. Changing them afterwards does not alter the result of that evaluation.
- R3: `done_o` is high for exactly one cycle, A+3 clock edges after the edge that accepted `start_i`. `busy_o` is high from the accepting edge until `done_o` rises, and is low while `done_o` is high.
- R4: Way j occupies bits [CW·j+CW−1 : CW·j] of `counts_i`. With S the sum of the A counts, `exceeds_o` is 1 exactly when 10000·Σj(A·ej − S)² > λ²·(A−1)·S², i.e. when the percent coefficient of variation is strictly greater than λ.
- R5: A vector of all-zero counts gives `exceeds_o` = 0 for any λ.
- R6: A vector of equal counts gives `exceeds_o` = 0 for any λ, including λ = 0.
- R7: When exactly one way is nonzero, the variation is 100·√A percent. `exceeds_o` is 1 exactly when λ² < 10000·A, so at A=16 it is 1 for λ=399 and 0 for λ=400.
- R8: A variation exactly equal to λ gives 0, because the comparison is strict.
- R9: Full-scale counts of 2^CW−1 are evaluated without overflow. At A=16, alternating full-scale and zero ways gives a variation of 400/√15 ≈ 103.3, so the result is 1 for λ=103 and 0 for λ=104.
- R10: `start_i` while `busy_o` is high is ignored. The running evaluation keeps its latency and its result.
- R11: `exceeds_o` holds its value from one `done_o` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an evaluation (accepted when idle) |
| lambda_i | input | LW | Threshold in whole percent |
| counts_i | input | A·CW | Packed per-way write counts, way 0 in the low bits |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| exceeds_o | output | 1 | Variation strictly above threshold; held between strobes |

## Verification
A broken way index or a broken shift of the captured counts shows up in two ways: `done_o` arrives on the wrong cycle, or the accumulated sums come out wrong. The bench compares `done_o` and `busy_o` against a reference on every clock, so a timing fault is caught within A+3 cycles of a start. A truncated product or a wrong derived width only affects the flag. The boundary patterns are chosen so that the true variation sits one percent either side of λ, and at full-scale counts. A single wrong bit in the arithmetic therefore flips `exceeds_o` at the very next `done_o`.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  // Square of the percent scale factor (100^2)
  localparam int PCT_SQ = 10000;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACC  = 3'd1,
    ST_SQ   = 3'd2,
    ST_MUL  = 3'd3,
    ST_CMP  = 3'd4
  } cvt_state_e;
endpackage

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
#(
  parameter int A = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic acc_o,
  output logic sq_o,
  output logic mul_o,
  output logic cmp_o,
  output logic busy_o
);
  localparam int IW = (A > 1) ? $clog2(A) : 1;

  cvt_state_e      st_q, st_d;
  logic [IW-1:0]   idx_q, idx_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    load_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_ACC;
          idx_d  = '0;
          load_o = 1'b1;
        end
      end
      ST_ACC: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(A - 1)) st_d = ST_SQ;
      end
      ST_SQ:   st_d = ST_MUL;
      ST_MUL:  st_d = ST_CMP;
      default: st_d = ST_IDLE;
    endcase
  end

  assign acc_o  = (st_q == ST_ACC);
  assign sq_o   = (st_q == ST_SQ);
  assign mul_o  = (st_q == ST_MUL);
  assign cmp_o  = (st_q == ST_CMP);
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/cvt_accum.sv
module cvt_accum #(
  parameter int A  = 16,
  parameter int CW = 40
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_i,
  input  logic                               acc_i,
  input  logic [A*CW-1:0]                    counts_i,
  output logic [CW+$clog2(A+1)-1:0]          s1_o,
  output logic [2*CW+$clog2(A+1)-1:0]        s2_o
);
  localparam int KW  = $clog2(A + 1);
  localparam int S1W = CW + KW;
  localparam int S2W = 2 * CW + KW;

  logic [A-1:0][CW-1:0] sh_q, sh_d;
  logic [S1W-1:0]       s1_q, s1_d;
  logic [S2W-1:0]       s2_q, s2_d;

  // Way 0 is always at the head; the vector moves down one way per step
  always_comb begin
    sh_d[A-1] = '0;
  end

  generate
    for (genvar g = 0; g < A - 1; g++) begin : g_shift
      always_comb sh_d[g] = sh_q[g+1];
    end
  endgenerate

  always_comb begin
    s1_d = s1_q + S1W'(sh_q[0]);
    s2_d = s2_q + S2W'(S2W'(sh_q[0]) * S2W'(sh_q[0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      s1_q <= '0;
      s2_q <= '0;
    end else if (load_i) begin
      sh_q <= counts_i;
      s1_q <= '0;
      s2_q <= '0;
    end else if (acc_i) begin
      sh_q <= sh_d;
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign s1_o = s1_q;
  assign s2_o = s2_q;
endmodule

// File: rtl/cvt_compare.sv
module cvt_compare
  import cvt_pkg::*;
#(
  parameter int A  = 16,
  parameter int CW = 40,
  parameter int LW = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          sq_i,
  input  logic                          mul_i,
  input  logic                          cmp_i,
  input  logic [LW-1:0]                 lambda_i,
  input  logic [CW+$clog2(A+1)-1:0]     s1_i,
  input  logic [2*CW+$clog2(A+1)-1:0]   s2_i,
  output logic                          done_o,
  output logic                          flag_o
);
  localparam int KW   = $clog2(A + 1);
  localparam int S1W  = CW + KW;
  localparam int DW   = 2 * CW + 2 * KW;
  localparam int SQW  = 2 * S1W;
  localparam int LHSW = DW + 14 + KW;
  localparam int RHSW = 2 * LW + KW + SQW;
  localparam int MW   = ((LHSW > RHSW) ? LHSW : RHSW) + 1;

  logic [LW-1:0]  lam_q;
  logic [DW-1:0]  dev_q, dev_d;
  logic [SQW-1:0] s1sq_q, s1sq_d;
  logic [MW-1:0]  lhs_q, lhs_d, rhs_q, rhs_d;
  logic           flag_q, flag_d, done_q;

  always_comb begin
    // A*sum(e^2) - (sum e)^2 equals A times the summed squared deviation
    dev_d  = DW'(A) * DW'(s2_i) - DW'(s1_i) * DW'(s1_i);
    s1sq_d = SQW'(s1_i) * SQW'(s1_i);
    lhs_d  = MW'(PCT_SQ * A) * MW'(dev_q);
    rhs_d  = MW'(lam_q) * MW'(lam_q) * MW'(A - 1) * MW'(s1sq_q);
    flag_d = (lhs_q > rhs_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lam_q  <= '0;
      dev_q  <= '0;
      s1sq_q <= '0;
      lhs_q  <= '0;
      rhs_q  <= '0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= cmp_i;
      if (load_i) lam_q <= lambda_i;
      if (sq_i) begin
        dev_q  <= dev_d;
        s1sq_q <= s1sq_d;
      end
      if (mul_i) begin
        lhs_q <= lhs_d;
        rhs_q <= rhs_d;
      end
      if (cmp_i) flag_q <= flag_d;
    end
  end

  assign done_o = done_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cv_threshold_check.sv
module cv_threshold_check #(
  parameter int A  = 16,
  parameter int CW = 40,
  parameter int LW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [LW-1:0]   lambda_i,
  input  logic [A*CW-1:0] counts_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            exceeds_o
);
  localparam int KW  = $clog2(A + 1);
  localparam int S1W = CW + KW;
  localparam int S2W = 2 * CW + KW;

  logic           load, acc, sq, mul, cmp;
  logic [S1W-1:0] s1;
  logic [S2W-1:0] s2;

  cvt_ctrl #(.A(A)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .acc_o   (acc),
    .sq_o    (sq),
    .mul_o   (mul),
    .cmp_o   (cmp),
    .busy_o  (busy_o)
  );

  cvt_accum #(.A(A), .CW(CW)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .acc_i    (acc),
    .counts_i (counts_i),
    .s1_o     (s1),
    .s2_o     (s2)
  );

  cvt_compare #(.A(A), .CW(CW), .LW(LW)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .sq_i     (sq),
    .mul_i    (mul),
    .cmp_i    (cmp),
    .lambda_i (lambda_i),
    .s1_i     (s1),
    .s2_i     (s2),
    .done_o   (done_o),
    .flag_o   (exceeds_o)
  );
endmodule

// File: rtl/cv_threshold_check_chk.sv
module cv_threshold_check_chk #(
  parameter int A  = 16,
  parameter int CW = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [A*CW-1:0] counts_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            exceeds_o
);
  logic [15:0] cnt_q;
  logic        zero_q, equal_q, equal_now;

  always_comb begin
    equal_now = 1'b1;
    for (int j = 1; j < A; j++)
      if (counts_i[j*CW +: CW] != counts_i[CW-1:0]) equal_now = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      zero_q  <= 1'b0;
      equal_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      cnt_q   <= 16'd1;
      zero_q  <= (counts_i == '0);
      equal_q <= equal_now;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 16'd1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !done_o);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == 16'(A + 4)));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q <= 16'(A + 3)));

  a_r11_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(exceeds_o));

  a_r5_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_q) |-> !exceeds_o);

  a_r6_equal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && equal_q) |-> !exceeds_o);
endmodule

bind cv_threshold_check cv_threshold_check_chk #(.A(A), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .counts_i  (counts_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .exceeds_o (exceeds_o)
);

// File: tb/sim_cv_threshold_check.sv
module sim_cv_threshold_check;
  localparam int A  = 16;
  localparam int CW = 40;
  localparam int LW = 9;
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic            clk, rst_n, start;
  logic [LW-1:0]   lam;
  logic [A*CW-1:0] counts;
  logic            busy_o, done_o, exceeds_o;

  int checks, fails, cycles;

  cv_threshold_check #(.A(A), .CW(CW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lambda_i(lam),
    .counts_i(counts), .busy_o(busy_o), .done_o(done_o), .exceeds_o(exceeds_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R4: direct-deviation form of the strict percent comparison
  function automatic logic ref_flag(input logic [A*CW-1:0] c, input logic [LW-1:0] l);
    logic signed [255:0] tot, dev, ssq, lhs, rhs;
    tot = '0;
    ssq = '0;
    for (int j = 0; j < A; j++) tot = tot + 256'(c[j*CW +: CW]);
    for (int j = 0; j < A; j++) begin
      dev = 256'(c[j*CW +: CW]) * A - tot;
      ssq = ssq + dev * dev;
    end
    lhs = ssq * 10000;
    rhs = 256'(l) * 256'(l) * (A - 1) * tot * tot;
    return lhs > rhs;
  endfunction

  function automatic logic [A*CW-1:0] fill(input logic [CW-1:0] v);
    logic [A*CW-1:0] r;
    for (int j = 0; j < A; j++) r[j*CW +: CW] = v;
    return r;
  endfunction

  function automatic logic [A*CW-1:0] one_way(input int w, input logic [CW-1:0] v);
    logic [A*CW-1:0] r;
    r = '0;
    r[w*CW +: CW] = v;
    return r;
  endfunction

  // Cycle-level reference model
  logic m_busy, m_done, m_flag, m_pend;
  int   m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_flag <= 1'b0; m_pend <= 1'b0; m_rem <= 0;
    end else if (m_busy) begin
      if (m_rem == 1) begin
        m_busy <= 1'b0; m_done <= 1'b1; m_flag <= m_pend;
      end else begin
        m_rem <= m_rem - 1; m_done <= 1'b0;
      end
    end else begin
      m_done <= 1'b0;
      if (start) begin
        m_busy <= 1'b1; m_rem <= A + 3; m_pend <= ref_flag(counts, lam);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks = checks + 3;
      if (busy_o !== m_busy) begin
        fails++; $display("FAIL R3 busy actual=%0b expected=%0b", busy_o, m_busy);
      end
      if (done_o !== m_done) begin
        fails++; $display("FAIL R3 done actual=%0b expected=%0b", done_o, m_done);
      end
      if (exceeds_o !== m_flag) begin
        fails++; $display("FAIL R4 exceeds actual=%0b expected=%0b", exceeds_o, m_flag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Run one evaluation; scramble inputs after acceptance (R2); check latency (R3)
  task automatic run(input logic [A*CW-1:0] c, input logic [LW-1:0] l,
                     input logic exp, input string tag, input bit restart);
    int n;
    @(negedge clk);
    counts = c; lam = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0; counts = ~c; lam = ~l;
    n = 1;
    while (!done_o) begin
      if (restart && n == 5) begin start = 1'b1; counts = '0; end
      if (restart && n == 6) start = 1'b0;
      @(negedge clk);
      n++;
    end
    checks++;
    if (n != A + 4) begin
      fails++; $display("FAIL R3 latency actual=%0d expected=%0d", n, A + 4);
    end
    check(tag, exceeds_o, exp);
    check("R4 model", exceeds_o, ref_flag(c, l));
  endtask

  initial begin
    logic [A*CW-1:0] pat;
    logic            held;
    checks = 0; fails = 0; cycles = 0;
    start = 1'b0; lam = '0; counts = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy", busy_o, 1'b0);
    check("R1 done", done_o, 1'b0);
    check("R1 exceeds", exceeds_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    run('0, 9'd15, 1'b0, "R5 all zero", 1'b0);
    run('0, 9'd0, 1'b0, "R5 all zero lambda 0", 1'b0);
    run(fill(40'd1000), 9'd0, 1'b0, "R6 equal lambda 0", 1'b0);
    run(one_way(5, 40'd777), 9'd399, 1'b1, "R7 single way 399", 1'b0);
    run(one_way(5, 40'd777), 9'd400, 1'b0, "R8 single way at exactly 400", 1'b0);
    run(one_way(15, FULL), 9'd399, 1'b1, "R9 full-scale single way", 1'b0);
    run(fill(FULL), 9'd0, 1'b0, "R9 all full-scale", 1'b0);
    for (int j = 0; j < A; j++) pat[j*CW +: CW] = (j % 2 == 0) ? FULL : '0;
    run(pat, 9'd103, 1'b1, "R9 alternating 103", 1'b0);
    run(pat, 9'd104, 1'b0, "R9 alternating 104", 1'b0);
    for (int j = 0; j < A; j++) pat[j*CW +: CW] = CW'(j * 100 + 50);
    run(pat, 9'd15, ref_flag(pat, 9'd15), "R4 ramp", 1'b0);
    run(pat, 9'd60, ref_flag(pat, 9'd60), "R4 ramp high lambda", 1'b0);
    pat = fill(40'd80);
    pat[CW-1:0] = 40'd8800;
    run(pat, 9'd15, 1'b1, "R4 hot way", 1'b0);
    run(one_way(2, 40'd5), 9'd15, 1'b1, "R10 restart ignored", 1'b1);
    held = exceeds_o;
    repeat (5) @(negedge clk);
    check("R11 held after done", exceeds_o, held);
    run(fill(40'd3), 9'd15, 1'b0, "R2 inputs captured", 1'b0);
    repeat (4) @(negedge clk);
    check("R11 held low", exceeds_o, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule